// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a synchronous SRAM with registered inputs and a registered read output. It is organised as byte lanes with a ninth parity bit per lane. An access starts on one of two address strobes, qualified by three synchronous chip selects. A processor-side strobe starts an access whose write, if any, is completed on the following clock. A controller-side strobe performs a write in the same clock. Read data leaves through an output register, so it reaches the data bus one clock after the address is taken. A back-to-back stream delivers one word per clock.

After an access has started, the cycles without a strobe continue it. A two-bit burst counter steps the low address bits in linear or interleaved order when the advance input is low. When the advance input is high, the counter holds the current address. The common data bus is split into an input, an output and a drive enable. The drive enable follows an asynchronous output enable. It is forced off after a write or a deselect, and during the first cycle of an access that starts from the deselected state. The default depth is kept small for elaboration; a full-size array is obtained by setting `ADDR_W` to 17.

Top module: `psb_sram`

## Requirements
- R1: After reset the device is deselected and `dq_oe` is low. Clock edges without a strobe start nothing while the device is deselected.
- R2: A read starts at a rising edge when a strobe is low, the chip selects are active and `gw_n` and `bwe_n` are both high. Active chip selects are `ce1_n`=0, `ce2`=1 and `ce3_n`=0. The read word is on `dq_out`, with `dq_oe` high, after the next rising edge. Consecutive read edges yield one word per clock.
- R3: `adsp_n` low is ignored at an edge where `ce1_n` is high. With the controller strobe high, such an edge acts as a plain continuation cycle.
- R4: An access started by `adsp_n` ignores the write inputs and `adv_n` at its starting edge. A write issued at the next edge stores `dq_in`, under the byte controls of that edge, at the captured address.
- R5: With `adsp_n` high (or ignored per R3), `adsc_n` low and a write input active, the write takes effect at that same edge and `adv_n` is ignored. If `adsp_n` is also low, the edge starts a read instead.
- R6: With `gw_n` low, all four lanes are written. Otherwise, with `bwe_n` low, lane i is written when `bw_n[i]` is 0 and other lanes keep their contents. Lane i occupies bits 9i+8 down to 9i: lane 0 is bits 8:0 and lane 3 is bits 35:27.
- R7: After an access starts from the deselected state, `dq_oe` stays low until the edge that follows the starting edge.
- R8: `dq_oe` is low after any edge at which a write is taken, whatever `oe_n` is.
- R9: `dq_oe` goes low right after an edge where a strobe is seen with the chip selects inactive.
- R10: `oe_n` gates `dq_oe` asynchronously, without waiting for a clock edge.
- R11: `adv_n` low in a continuation cycle steps the 2-bit burst counter before the access. `burst_lin`=1 gives the offset base+n mod 4, and `burst_lin`=0 gives base XOR n. The order is sampled at the starting edge. `adv_n` high repeats the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip select 1, active low |
| ce2 | input | 1 | Chip select 2, active high |
| ce3_n | input | 1 | Chip select 3, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES | Per-lane byte select, active low |
| burst_lin | input | 1 | Burst order at start: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANE_W*LANES | Write data from the bus |
| dq_out | output | LANE_W*LANES | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Reads are exercised in three forms: single reads, four-beat bursts from an unaligned base in each order, and a burst that holds its address with the advance input high. Only the bursts show whether the counter wraps linearly or by XOR. Writes are issued through both strobes, with all-lane, partial-lane and override masks. The processor-strobe case is given decoy data, a write request and an advance request on its first edge, which exposes a write latency or address that is off by one cycle. Strobe collisions are also driven: both strobes low, and the processor strobe low with chip select 1 high. These tell the priority and qualification rules apart from a plain strobe decode.

// File: rtl/psb_sram_pkg.sv
package psb_sram_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2
   } cyc_e;
endpackage

// File: rtl/psb_lane_mask.sv
module psb_lane_mask #(
   parameter int LANES = 4
) (
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   output logic             is_wr,
   output logic [LANES-1:0] mask
);
   assign is_wr = !gw_n || !bwe_n;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign mask[g] = !gw_n || (!bwe_n && !bw_n[g]);
   end
endmodule

// File: rtl/psb_burst_seq.sv
module psb_burst_seq #(
   parameter int BURST_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [BURST_W-1:0] load_base,
   input  logic               load_lin,
   input  logic               step,
   output logic [BURST_W-1:0] offs
);
   logic [BURST_W-1:0] base_q, cnt_q, cnt_nx;
   logic               lin_q;

   always_comb begin
      cnt_nx = step ? cnt_q + 1'b1 : cnt_q;
      if (load)       offs = load_base;
      else if (lin_q) offs = base_q + cnt_nx;
      else            offs = base_q ^ cnt_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         lin_q  <= 1'b1;
      end else if (load) begin
         base_q <= load_base;
         cnt_q  <= '0;
         lin_q  <= load_lin;
      end else begin
         cnt_q  <= cnt_nx;
      end
   end

   // R11: a hold cycle leaves the burst position untouched
   assert_burst_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> ($stable(base_q) && $stable(cnt_q)));
   // R11: a step cycle moves the counter
   assert_burst_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step) |=> (cnt_q != $past(cnt_q)));
endmodule

// File: rtl/psb_sram_core.sv
module psb_sram_core #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANE_W*LANES-1:0] wdata,
   input  logic                    re,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANE_W*LANES-1:0] rdata
);
   localparam int DEPTH = 2 ** ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] q;

      always_ff @(posedge clk) begin
         if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
         if (re)    q <= mem[raddr];
      end

      assign rdata[g*LANE_W +: LANE_W] = q;
   end
endmodule

// File: rtl/psb_sram.sv
module psb_sram
   import psb_sram_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int LANE_W  = 9,
   parameter int LANES   = 4,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    adsp_n,
   input  logic                    adsc_n,
   input  logic                    adv_n,
   input  logic                    ce1_n,
   input  logic                    ce2,
   input  logic                    ce3_n,
   input  logic                    gw_n,
   input  logic                    bwe_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic                    burst_lin,
   input  logic                    oe_n,
   input  logic [LANE_W*LANES-1:0] dq_in,
   output logic [LANE_W*LANES-1:0] dq_out,
   output logic                    dq_oe
);
   localparam int HI_W = ADDR_W - BURST_W;

   initial begin
      assert (BURST_W >= 1 && ADDR_W > BURST_W && LANES >= 1 && LANE_W >= 1)
         else $fatal(1, "psb_sram: bad parameter set");
   end

   logic              sel, proc_seen, ctrl_seen, strobe, start, desel, cont;
   logic              is_wr, ctrl_wr, acc_wr, acc_rd, step;
   logic [LANES-1:0]  mask, we;
   logic [BURST_W-1:0] offs;
   logic [ADDR_W-1:0] acc_addr, rd_addr_q;
   logic [HI_W-1:0]   hi_q;
   logic              active_q, drive_q;
   cyc_e              cyc, cyc_q;

   // strobe and select decode
   always_comb begin
      sel       = !ce1_n && ce2 && !ce3_n;
      proc_seen = !adsp_n && !ce1_n;
      ctrl_seen = !adsc_n && !proc_seen;
      strobe    = proc_seen || ctrl_seen;
      start     = strobe && sel;
      desel     = strobe && !sel;
      cont      = !strobe && active_q;
      ctrl_wr   = ctrl_seen && sel && is_wr;
      acc_wr    = ctrl_wr || (cont && is_wr);
      acc_rd    = (start && !ctrl_wr) || (cont && !is_wr);
      step      = cont && !adv_n;
      acc_addr  = start ? addr : {hi_q, offs};
      we        = acc_wr ? mask : '0;
      if (acc_wr)      cyc = CYC_WRITE;
      else if (acc_rd) cyc = CYC_READ;
      else             cyc = CYC_IDLE;
   end

   psb_lane_mask #(.LANES(LANES)) u_mask (
      .gw_n  (gw_n),
      .bwe_n (bwe_n),
      .bw_n  (bw_n),
      .is_wr (is_wr),
      .mask  (mask)
   );

   psb_burst_seq #(.BURST_W(BURST_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .load_base (addr[BURST_W-1:0]),
      .load_lin  (burst_lin),
      .step      (step),
      .offs      (offs)
   );

   psb_sram_core #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_core (
      .clk   (clk),
      .we    (we),
      .waddr (acc_addr),
      .wdata (dq_in),
      .re    (cyc_q == CYC_READ),
      .raddr (rd_addr_q),
      .rdata (dq_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         hi_q      <= '0;
         cyc_q     <= CYC_IDLE;
         rd_addr_q <= '0;
         drive_q   <= 1'b0;
      end else begin
         if (start)      active_q <= 1'b1;
         else if (desel) active_q <= 1'b0;
         if (start) hi_q <= addr[ADDR_W-1:BURST_W];
         cyc_q     <= cyc;
         rd_addr_q <= acc_addr;
         drive_q   <= (cyc_q == CYC_READ) && !acc_wr && !desel;
      end
   end

   assign dq_oe = drive_q && !oe_n;

   // R8: a captured write turns the drivers off at the next cycle
   assert_wr_tristate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr |=> !dq_oe);
   // R9: a deselect turns the drivers off at once
   assert_desel_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      desel |=> !dq_oe);
   // R7: first cycle of an access from the deselected state stays quiet
   assert_first_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !active_q) |=> !dq_oe);
   // R3: processor strobe with ce1_n high changes no selection state
   assert_proc_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!adsp_n && ce1_n && adsc_n) |=> (active_q == $past(active_q)));
   // R1: without a started access, no drive follows
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !start) |=> !dq_oe);
endmodule

// File: tb/psb_sram_bench.sv
module psb_sram_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  addr;
   logic        adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n;
   logic [3:0]  bw_n;
   logic        burst_lin, oe_n;
   logic [35:0] dq_in, dq_out;
   logic        dq_oe;
   int          n_chk = 0;
   int          n_fail = 0;

   always #10 clk = ~clk;

   psb_sram u_psb_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
      .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
      .bwe_n(bwe_n), .bw_n(bw_n), .burst_lin(burst_lin), .oe_n(oe_n),
      .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one clock: inputs set after a falling edge, result sampled at the next falling edge
   task automatic op(input logic p, input logic c, input logic adv,
                     input logic c1, input logic c2, input logic c3,
                     input logic g, input logic be, input logic [3:0] bws,
                     input logic [7:0] a, input logic [35:0] d);
      adsp_n = p; adsc_n = c; adv_n = adv; ce1_n = c1; ce2 = c2; ce3_n = c3;
      gw_n = g; bwe_n = be; bw_n = bws; addr = a; dq_in = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic desel();
      op(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 8'h00, 36'h0);
   endtask
   task automatic c_wr(input logic [7:0] a, input logic [35:0] d);
      op(1, 0, 1, 0, 1, 0, 0, 1, 4'hF, a, d);
   endtask
   task automatic c_rd(input logic [7:0] a);
      op(1, 0, 1, 0, 1, 0, 1, 1, 4'hF, a, 36'h0);
   endtask
   task automatic cont(input logic adv, input logic g, input logic [35:0] d);
      op(1, 1, adv, 0, 1, 0, g, 1, 4'hF, 8'h00, d);
   endtask
   task automatic readback(input string req, input logic [7:0] a, input logic [35:0] exp);
      c_rd(a);
      cont(1, 1, 36'h0);
      check(req, {35'h0, dq_oe}, 36'h1);
      check(req, dq_out, exp);
   endtask

   task automatic t_reset();
      check("R1 reset drive", {35'h0, dq_oe}, 36'h0);
      cont(1, 0, 36'h123);
      check("R1 idle edge", {35'h0, dq_oe}, 36'h0);
   endtask

   task automatic t_ctrl_write();
      desel();
      c_wr(8'h10, 36'h9_8765_4321);
      c_rd(8'h10);
      check("R2 drive before data", {35'h0, dq_oe}, 36'h0);
      cont(1, 1, 36'h0);
      check("R2 read valid", {35'h0, dq_oe}, 36'h1);
      check("R5 single-cycle write", dq_out, 36'h9_8765_4321);
   endtask

   task automatic t_byte_write();
      c_wr(8'h11, 36'hF_FFFF_FFFF);
      op(1, 0, 1, 0, 1, 0, 1, 0, 4'b1010, 8'h11, 36'h0);
      readback("R6 lanes 0 and 2", 8'h11, {9'h1FF, 9'h000, 9'h1FF, 9'h000});
      op(1, 0, 1, 0, 1, 0, 0, 0, 4'b1111, 8'h11, 36'h1_2345_6789);
      readback("R6 global override", 8'h11, 36'h1_2345_6789);
   endtask

   task automatic t_proc_write();
      c_wr(8'h20, 36'h0_0000_00A0);
      c_wr(8'h21, 36'h0_0000_00A1);
      desel();
      op(0, 1, 0, 0, 1, 0, 0, 1, 4'hF, 8'h20, 36'hB_AD00_0BAD);
      check("R7 first cycle quiet", {35'h0, dq_oe}, 36'h0);
      cont(1, 0, 36'h5_5555_AAAA);
      check("R8 write drive off", {35'h0, dq_oe}, 36'h0);
      readback("R4 second-edge data", 8'h20, 36'h5_5555_AAAA);
      readback("R4 adv ignored at start", 8'h21, 36'h0_0000_00A1);
   endtask

   task automatic t_proc_ignored();
      c_wr(8'h40, 36'h0_0000_4040);
      c_wr(8'h55, 36'h0_0000_5555);
      c_rd(8'h40);
      op(0, 1, 1, 1, 1, 0, 1, 1, 4'hF, 8'h55, 36'h0);
      check("R3 still selected", {35'h0, dq_oe}, 36'h1);
      check("R3 first word", dq_out, 36'h0_0000_4040);
      cont(1, 1, 36'h0);
      check("R3 address not reloaded", dq_out, 36'h0_0000_4040);
   endtask

   task automatic t_both_strobes();
      c_wr(8'h60, 36'h0_0000_0660);
      op(0, 0, 1, 0, 1, 0, 0, 1, 4'hF, 8'h60, 36'hE_EEEE_EEEE);
      cont(1, 1, 36'h0);
      check("R5 both strobes read", dq_out, 36'h0_0000_0660);
   endtask

   task automatic t_burst(input logic lin, input logic [1:0] base,
                          input logic [1:0] o1, input logic [1:0] o2,
                          input logic [1:0] o3, input string req);
      for (int i = 0; i < 4; i++) c_wr(8'h30 + 8'(i), 36'(32'hC0DE_0000 + i));
      burst_lin = lin;
      c_rd(8'h30 + 8'(base));
      burst_lin = ~lin;
      cont(0, 1, 36'h0);
      check(req, dq_out, 36'(32'hC0DE_0000 + base));
      cont(0, 1, 36'h0);
      check(req, dq_out, 36'(32'hC0DE_0000 + o1));
      cont(0, 1, 36'h0);
      check(req, dq_out, 36'(32'hC0DE_0000 + o2));
      cont(1, 1, 36'h0);
      check(req, dq_out, 36'(32'hC0DE_0000 + o3));
      cont(1, 1, 36'h0);
      check("R11 hold repeats", dq_out, 36'(32'hC0DE_0000 + o3));
      check("R2 one word per clock", {35'h0, dq_oe}, 36'h1);
   endtask

   task automatic t_output_rules();
      c_wr(8'h70, 36'h0_0000_7777);
      c_rd(8'h70);
      cont(1, 1, 36'h0);
      oe_n = 1'b1;
      #1;
      check("R10 oe_n high", {35'h0, dq_oe}, 36'h0);
      oe_n = 1'b0;
      #1;
      check("R10 oe_n low", {35'h0, dq_oe}, 36'h1);
      cont(1, 0, 36'h0_0000_7777);
      check("R8 continuation write", {35'h0, dq_oe}, 36'h0);
      c_rd(8'h70);
      cont(1, 1, 36'h0);
      desel();
      check("R9 deselect off", {35'h0, dq_oe}, 36'h0);
      cont(1, 0, 36'h0_0000_0BAD);
      readback("R1 ignored while deselected", 8'h70, 36'h0_0000_7777);
   endtask

   initial begin
      rst_n = 1'b0; adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 1; ce2 = 0; ce3_n = 1;
      gw_n = 1; bwe_n = 1; bw_n = 4'hF; burst_lin = 1; oe_n = 0; addr = 0; dq_in = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl_write();
      t_byte_write();
      t_proc_write();
      t_proc_ignored();
      t_both_strobes();
      t_burst(1'b1, 2'd2, 2'd3, 2'd0, 2'd1, "R11 linear");
      t_burst(1'b0, 2'd1, 2'd0, 2'd3, 2'd2, "R11 interleaved");
      t_output_rules();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule